// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

The bridge gives a host, through a handful of 32-bit registers, access to many endpoints on a sideband fabric. The host stages an upper offset and a data word, then writes a command register holding an opcode, a target port, the low offset byte, a byte-enable field and a modify flag. That command write is the single trigger. The bridge builds one request from these fields and drives it on a request/response port. It holds the request until the endpoint answers or a cycle timeout expires.

Opcode bit 0 sets the direction. A write request carries the staged data word. A read request returns a word that the bridge stores in the data register. When the modify flag is set, the bridge runs a read and then a write to the same location as one unbroken sequence. The written value keeps the old bits outside a mask and takes the staged data inside it. One port number is reserved: a command aimed at it is refused and is never issued.

Status shows busy, done, a sticky error and a refusal flag. While busy is set, command writes are ignored.

Top module: `mbx_bridge`

## Requirements
- R1: Register word addresses are: 0 command, 1 extended offset, 2 data, 3 mask, 4 status. The command fields are opcode [31:24], port [23:16], low offset [15:8], byte enables [7:4] and modify flag [0]. The issued offset is extended-offset bits [31:8] joined with command bits [15:8], and the request carries the opcode, port and enables unchanged.
- R2: Only a command write starts a request. Writes to the extended offset, data and mask registers only stage values.
- R3: A command write with a zero byte-enable field issues nothing and leaves busy clear.
- R4: With opcode bit 0 = 1, the request is a write that carries the data register as its write data.
- R5: With opcode bit 0 = 0, the response word is stored in the data register, and later host reads of that register return it.
- R6: A command whose port equals the reserved port is never issued. It sets status error (bit 2) and refused (bit 3).
- R7: Status bit 0 (busy) is set from the command write until the operation ends, and any command write made while busy is ignored.
- R8: If no response arrives within TO_CYC cycles of a phase, the request is withdrawn, busy clears, the error bit is set and the data register keeps its value.
- R9: A modify issues a read with opcode bit 0 cleared, then a write with bit 0 set and data (old & ~mask) | (data & mask). No other request comes between them, and the data register is not changed.
- R10: The error bit stays set until a status write with bit 2 = 1, which clears both error and refused. Status bit 1 (done) is set when an operation completes and is cleared by the next accepted command.
- R11: After reset, status, data and all staging registers read 0 and no request is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe; data valid next cycle |
| hst_addr | input | 3 | Host register word address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, registered |
| sb_req_valid | output | 1 | Sideband request held until answered or timed out |
| sb_opcode | output | 8 | Request opcode |
| sb_port | output | 8 | Target endpoint port |
| sb_offset | output | 32 | Full register offset |
| sb_be | output | 4 | Byte enables |
| sb_wdata | output | 32 | Write data |
| sb_rsp_valid | input | 1 | One-cycle response strobe |
| sb_rsp_data | input | 32 | Response read data |

## Verification
The bench builds the bridge with TO_CYC = 16 and the reserved port at 0x0C. The short timeout lets a stalled endpoint, and the recovery after it, finish within a few dozen cycles. The bench's endpoint model has a variable response latency. With a long latency, a second command lands while the first is still outstanding, so the busy lockout can be observed.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  localparam logic [AW-1:0] A_CMD = 3'd0;
  localparam logic [AW-1:0] A_EXT = 3'd1;
  localparam logic [AW-1:0] A_DAT = 3'd2;
  localparam logic [AW-1:0] A_MSK = 3'd3;
  localparam logic [AW-1:0] A_STS = 3'd4;

  typedef enum logic [1:0] {PH_IDLE, PH_RD, PH_WR} phase_e;

  // merged write value of a masked modify
  function automatic logic [DW-1:0] mask_merge(input logic [DW-1:0] old_v,
                                               input logic [DW-1:0] new_v,
                                               input logic [DW-1:0] msk);
    return (old_v & ~msk) | (new_v & msk);
  endfunction
endpackage

// File: rtl/mbx_regs.sv
module mbx_regs
  import mbx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [AW-1:0] hst_addr,
  input  logic [DW-1:0] hst_wdata,
  output logic [DW-1:0] hst_rdata,
  input  logic          busy,
  input  logic          done,
  input  logic          err,
  input  logic          refused,
  input  logic          cap_valid,
  input  logic [DW-1:0] cap_data,
  output logic          launch,
  output logic [7:0]    l_op,
  output logic [7:0]    l_port,
  output logic [DW-1:0] l_ofs,
  output logic [3:0]    l_be,
  output logic          l_mod,
  output logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_mask,
  output logic          err_clr
);
  logic [DW-1:8] ext_q;
  logic [DW-1:0] dat_q, msk_q;
  logic [7:0]    op_q, port_q, lofs_q;
  logic [3:0]    be_q;
  logic          mod_q;
  logic          cmd_wr, cmd_take;

  assign cmd_wr   = hst_wr && (hst_addr == A_CMD);
  assign cmd_take = cmd_wr && !busy;
  assign launch   = cmd_take && (hst_wdata[7:4] != 4'd0);
  assign err_clr  = hst_wr && (hst_addr == A_STS) && hst_wdata[2];

  assign l_op    = hst_wdata[31:24];
  assign l_port  = hst_wdata[23:16];
  assign l_ofs   = {ext_q, hst_wdata[15:8]};
  assign l_be    = hst_wdata[7:4];
  assign l_mod   = hst_wdata[0];
  assign l_wdata = dat_q;
  assign l_mask  = msk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_q <= '0; dat_q <= '0; msk_q <= '0;
      op_q <= '0; port_q <= '0; lofs_q <= '0; be_q <= '0; mod_q <= 1'b0;
      hst_rdata <= '0;
    end else begin
      if (cmd_take) begin
        op_q <= hst_wdata[31:24]; port_q <= hst_wdata[23:16];
        lofs_q <= hst_wdata[15:8]; be_q <= hst_wdata[7:4]; mod_q <= hst_wdata[0];
      end
      if (hst_wr && hst_addr == A_EXT) ext_q <= hst_wdata[DW-1:8];
      if (hst_wr && hst_addr == A_MSK) msk_q <= hst_wdata;
      if (cap_valid) dat_q <= cap_data;
      else if (hst_wr && hst_addr == A_DAT) dat_q <= hst_wdata;
      if (hst_rd) begin
        unique case (hst_addr)
          A_CMD:   hst_rdata <= {op_q, port_q, lofs_q, be_q, 3'b000, mod_q};
          A_EXT:   hst_rdata <= {ext_q, 8'h00};
          A_DAT:   hst_rdata <= dat_q;
          A_MSK:   hst_rdata <= msk_q;
          A_STS:   hst_rdata <= {28'd0, refused, err, done, busy};
          default: hst_rdata <= '0;
        endcase
      end
    end
  end

  // R5: data register changes only by capture or a host write
  assert_dat_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_valid && !(hst_wr && hst_addr == A_DAT)) |=> $stable(dat_q));
  // R7: a command write seen while busy does not launch
  assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_wr) |-> !launch);
endmodule

// File: rtl/mbx_seq.sv
module mbx_seq
  import mbx_pkg::*;
#(
  parameter int          TO_CYC      = 1000,
  parameter logic [7:0]  FORBID_PORT = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [7:0]    l_op,
  input  logic [7:0]    l_port,
  input  logic [DW-1:0] l_ofs,
  input  logic [3:0]    l_be,
  input  logic          l_mod,
  input  logic [DW-1:0] l_wdata,
  input  logic [DW-1:0] l_mask,
  input  logic          err_clr,
  output logic          sb_req_valid,
  output logic [7:0]    sb_opcode,
  output logic [7:0]    sb_port,
  output logic [DW-1:0] sb_offset,
  output logic [3:0]    sb_be,
  output logic [DW-1:0] sb_wdata,
  input  logic          sb_rsp_valid,
  input  logic [DW-1:0] sb_rsp_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          refused,
  output logic          cap_valid,
  output logic [DW-1:0] cap_data
);
  localparam int CW = $clog2(TO_CYC + 1);

  phase_e        ph;
  logic [7:0]    op_q, port_q;
  logic [DW-1:0] ofs_q, wd_q, msk_q;
  logic [3:0]    be_q;
  logic          mod_q;
  logic [CW-1:0] cnt;
  logic          expire, refuse_evt, rd_last;

  assign busy         = (ph != PH_IDLE);
  assign sb_req_valid = busy;
  assign sb_port      = port_q;
  assign sb_offset    = ofs_q;
  assign sb_be        = be_q;
  assign sb_wdata     = wd_q;
  assign sb_opcode    = !mod_q ? op_q :
                        (ph == PH_WR) ? (op_q | 8'h01) : (op_q & 8'hFE);
  assign expire     = busy && !sb_rsp_valid && (cnt == CW'(TO_CYC - 1));
  assign refuse_evt = launch && (l_port == FORBID_PORT);
  assign rd_last    = (ph == PH_RD) && sb_rsp_valid && !mod_q;
  assign cap_valid  = rd_last;
  assign cap_data   = sb_rsp_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= PH_IDLE; op_q <= '0; port_q <= '0; ofs_q <= '0; wd_q <= '0;
      msk_q <= '0; be_q <= '0; mod_q <= 1'b0; cnt <= '0;
      done <= 1'b0; err <= 1'b0; refused <= 1'b0;
    end else begin
      if (err_clr) begin err <= 1'b0; refused <= 1'b0; end
      unique case (ph)
        PH_IDLE: if (launch) begin
          done <= 1'b0;
          if (refuse_evt) begin
            err <= 1'b1; refused <= 1'b1;
          end else begin
            op_q <= l_op; port_q <= l_port; ofs_q <= l_ofs; be_q <= l_be;
            mod_q <= l_mod; wd_q <= l_wdata; msk_q <= l_mask; cnt <= '0;
            refused <= 1'b0;
            ph <= (l_op[0] && !l_mod) ? PH_WR : PH_RD;
          end
        end
        PH_RD: if (sb_rsp_valid) begin
          cnt <= '0;
          if (mod_q) begin
            wd_q <= mask_merge(sb_rsp_data, wd_q, msk_q);
            ph <= PH_WR;
          end else begin
            ph <= PH_IDLE; done <= 1'b1;
          end
        end else if (expire) begin
          ph <= PH_IDLE; err <= 1'b1;
        end else cnt <= cnt + 1'b1;
        PH_WR: if (sb_rsp_valid) begin
          ph <= PH_IDLE; done <= 1'b1;
        end else if (expire) begin
          ph <= PH_IDLE; err <= 1'b1;
        end else cnt <= cnt + 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R6: the reserved port never appears on the fabric
  assert_no_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid |-> (sb_port != FORBID_PORT));
  // R2: a request only begins after a command launch
  assert_start_by_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req_valid) |-> $past(launch));
  // R7: an accepted launch yields a request or a refusal next cycle
  assert_launch_acts_R7: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (sb_req_valid || refused));
  // R8: an unanswered request is held unless it expires
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req_valid && !sb_rsp_valid && !expire) |=> sb_req_valid);
  // R9: the read phase of a modify is followed by its write phase
  assert_mod_atomic_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_RD && mod_q && sb_rsp_valid) |=> (sb_req_valid && sb_opcode[0]));
  // R10: error stays set until cleared
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
endmodule

// File: rtl/mbx_bridge.sv
module mbx_bridge
  import mbx_pkg::*;
#(
  parameter int         TO_CYC      = 1000,
  parameter logic [7:0] FORBID_PORT = 8'h0C
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [2:0]    hst_addr,
  input  logic [31:0]   hst_wdata,
  output logic [31:0]   hst_rdata,
  output logic          sb_req_valid,
  output logic [7:0]    sb_opcode,
  output logic [7:0]    sb_port,
  output logic [31:0]   sb_offset,
  output logic [3:0]    sb_be,
  output logic [31:0]   sb_wdata,
  input  logic          sb_rsp_valid,
  input  logic [31:0]   sb_rsp_data
);
  logic          launch, l_mod, err_clr, busy, done, err, refused, cap_valid;
  logic [7:0]    l_op, l_port;
  logic [3:0]    l_be;
  logic [DW-1:0] l_ofs, l_wdata, l_mask, cap_data;

  mbx_regs u_regs (
    .clk, .rst_n, .hst_wr, .hst_rd, .hst_addr, .hst_wdata, .hst_rdata,
    .busy, .done, .err, .refused, .cap_valid, .cap_data,
    .launch, .l_op, .l_port, .l_ofs, .l_be, .l_mod, .l_wdata, .l_mask, .err_clr
  );

  mbx_seq #(.TO_CYC(TO_CYC), .FORBID_PORT(FORBID_PORT)) u_seq (
    .clk, .rst_n, .launch, .l_op, .l_port, .l_ofs, .l_be, .l_mod, .l_wdata,
    .l_mask, .err_clr, .sb_req_valid, .sb_opcode, .sb_port, .sb_offset,
    .sb_be, .sb_wdata, .sb_rsp_valid, .sb_rsp_data,
    .busy, .done, .err, .refused, .cap_valid, .cap_data
  );
endmodule

// File: tb/sim_mbx_bridge.sv
`timescale 1ns/1ps
module sim_mbx_bridge;
  logic clk = 1'b0, rst_n = 1'b0;
  logic hst_wr = 1'b0, hst_rd = 1'b0;
  logic [2:0] hst_addr = '0;
  logic [31:0] hst_wdata = '0, hst_rdata;
  logic sb_req_valid, sb_rsp_valid;
  logic [7:0] sb_opcode, sb_port;
  logic [31:0] sb_offset, sb_wdata, sb_rsp_data;
  logic [3:0] sb_be;

  always #4 clk = ~clk;

  mbx_bridge #(.TO_CYC(16), .FORBID_PORT(8'h0C)) u0 (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // endpoint model
  logic [31:0] mem [16];
  int lat = 2, cnt = 0, txn = 0;
  bit stall = 0, reserved_seen = 0;
  bit poke_en = 0; logic [3:0] poke_idx = '0; logic [31:0] poke_val = '0;
  logic [7:0] last_op, last_port, prev_op; logic [31:0] last_ofs; logic [3:0] last_be;
  logic rsp_r = 1'b0; logic [31:0] rsp_d = '0;
  assign sb_rsp_valid = rsp_r;
  assign sb_rsp_data  = rsp_d;

  always @(posedge clk) begin
    if (poke_en) mem[poke_idx] <= poke_val;
    if (sb_req_valid && sb_port == 8'h0C) reserved_seen <= 1;
    if (rsp_r) begin rsp_r <= 1'b0; cnt <= 0; end
    else if (sb_req_valid && !stall) begin
      if (cnt >= lat) begin
        rsp_r <= 1'b1; txn <= txn + 1;
        prev_op <= last_op; last_op <= sb_opcode; last_port <= sb_port;
        last_ofs <= sb_offset; last_be <= sb_be;
        if (sb_opcode[0]) mem[sb_offset[3:0]] <= sb_wdata;
        else rsp_d <= mem[sb_offset[3:0]];
      end else cnt <= cnt + 1;
    end else cnt <= 0;
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic hwr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); hst_wr = 1; hst_addr = a; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic hrd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk); hst_rd = 1; hst_addr = a;
    @(negedge clk); hst_rd = 0; d = hst_rdata;
  endtask

  task automatic poke(logic [3:0] i, logic [31:0] v);
    @(negedge clk); poke_en = 1; poke_idx = i; poke_val = v;
    @(negedge clk); poke_en = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int i = 0; i < 100; i++) begin
      hrd(3'd4, s);
      if (!s[0]) return;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hrd(3'd4, v); check("R11 status", v, 0);
    hrd(3'd2, v); check("R11 data", v, 0);
    hrd(3'd1, v); check("R11 ext", v, 0);
    check("R11 req idle", {31'd0, sb_req_valid}, 0);
  endtask

  task automatic t_write();
    int t0 = txn; logic [31:0] v;
    hwr(3'd2, 32'hA5A5_1234);
    hwr(3'd1, 32'h0001_2300);
    hwr(3'd3, 32'h0000_0000);
    check("R2 staging issues nothing", txn, t0);
    hwr(3'd0, 32'h1103_05F0);
    wait_idle();
    check("R4 write data", mem[5], 32'hA5A5_1234);
    check("R1 offset", last_ofs, 32'h0001_2305);
    check("R1 port/op/be", {last_op, last_port, 12'd0, last_be}, {8'h11, 8'h03, 12'd0, 4'hF});
    hrd(3'd4, v); check("R10 done", v, 32'h2);
  endtask

  task automatic t_read();
    logic [31:0] v;
    poke(4'd9, 32'hDEAD_BEEF);
    hwr(3'd1, 32'h0);
    hwr(3'd0, 32'h1002_0930);
    wait_idle();
    check("R5 opcode read", last_op, 8'h10);
    hrd(3'd2, v); check("R5 captured data", v, 32'hDEAD_BEEF);
  endtask

  task automatic t_enable0();
    int t0 = txn; logic [31:0] v;
    hwr(3'd0, 32'h1002_0900);
    repeat (6) @(negedge clk);
    check("R3 no request", txn, t0);
    hrd(3'd4, v); check("R3 busy clear", {31'd0, v[0]}, 0);
  endtask

  task automatic t_reserved();
    int t0 = txn; logic [31:0] v;
    hwr(3'd0, 32'h110C_01F0);
    repeat (6) @(negedge clk);
    check("R6 not issued", txn, t0);
    check("R6 never on fabric", {31'd0, reserved_seen}, 0);
    hrd(3'd4, v); check("R6 err+refused", v, 32'hC);
    hrd(3'd4, v); check("R10 sticky", v, 32'hC);
    hwr(3'd4, 32'h4);
    hrd(3'd4, v); check("R10 cleared", v, 32'h0);
  endtask

  task automatic t_busy();
    int t0 = txn;
    poke(4'd2, 32'h0000_0002);
    lat = 8;
    hwr(3'd0, 32'h1002_01F0);
    hwr(3'd2, 32'h5555_AAAA);
    hwr(3'd0, 32'h1102_02F0);
    wait_idle();
    repeat (4) @(negedge clk);
    check("R7 one request", txn, t0 + 1);
    check("R7 ignored write", mem[2], 32'h0000_0002);
    lat = 2;
  endtask

  task automatic t_timeout();
    logic [31:0] v;
    hwr(3'd2, 32'h0BAD_F00D);
    stall = 1;
    hwr(3'd0, 32'h1002_03F0);
    repeat (25) @(negedge clk);
    check("R8 request withdrawn", {31'd0, sb_req_valid}, 0);
    hrd(3'd4, v); check("R8 err, not busy", v & 32'h5, 32'h4);
    hrd(3'd2, v); check("R8 data kept", v, 32'h0BAD_F00D);
    stall = 0;
    hwr(3'd4, 32'h4);
  endtask

  task automatic t_modify();
    int t0; logic [31:0] v;
    poke(4'd4, 32'hFFFF_0000);
    hwr(3'd2, 32'h1234_5678);
    hwr(3'd3, 32'h00FF_FF00);
    t0 = txn;
    hwr(3'd0, 32'h1102_04F1);
    wait_idle();
    repeat (2) @(negedge clk);
    check("R9 merged value", mem[4], 32'hFF34_5600);
    check("R9 two requests", txn, t0 + 2);
    check("R9 op order", {prev_op, last_op}, {8'h10, 8'h11});
    hrd(3'd2, v); check("R9 data untouched", v, 32'h1234_5678);
  endtask

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_write();
    t_read();
    t_enable0();
    t_reserved();
    t_busy();
    t_timeout();
    t_modify();
    finish_run();
  end
endmodule